// File: doc/BRIEF.md
# Peripheral Interrupt Register Block

This block collects up to eight interrupt inputs of one peripheral and presents them to software through a byte-wide register page. Each input passes through a synchronizer. A per-source mode bit selects level or edge detection. Two independent polarity bits per source select which level or which edge counts, so a source in edge mode may trigger on rising edges, on falling edges or on both. A detected condition sets a sticky status bit. That bit stays set until software writes a one to its position in an acknowledge register.

Enables change only through two strobe registers. A one written to the set register turns a source on, and a one written to the clear register turns it off. The pending vector is the sticky status gated by the enables, and one request line carries the OR of all pending bits. The upper byte of the 16-bit bus address must equal the page number given by a parameter. Otherwise the access is ignored and reads return zero.

Top module: `pirq_regblk`

## Requirements
- R1: An access whose upper address byte differs from `PAGE_ID` changes no register and reads back 0x00.
- R2: Register offsets within the page: 0x10 raw level, 0x11 mode, 0x12 high polarity, 0x13 low polarity, 0x14 acknowledge, 0x15 enable-set, 0x16 enable-clear, 0x18 sticky status, 0x19 pending, 0x1A routing, 0x1B urgency. Bit n of every per-source register belongs to source n. Offsets 0x11 to 0x15 read as five consecutive bytes: mode, high polarity, low polarity, zero, current enable mask. Offset 0x16 and every unlisted offset read 0x00.
- R3: Offset 0x10 shows the synchronized inputs. A change on `src_in` that is present before rising edge k becomes visible after edge k+1.
- R4: In edge mode (mode bit 1), the sticky bit is set on a synchronized 0-to-1 change when the high polarity bit is 1, and on a 1-to-0 change when the low polarity bit is 1. With both polarity bits set, it is set on either change.
- R5: In level mode (mode bit 0), the sticky bit is set in every cycle in which the synchronized input is 1 with high polarity, or 0 with low polarity. The bit therefore re-appears after an acknowledge while that level persists.
- R6: A write to 0x15 sets the enable bits written as 1, and a write to 0x16 clears them. Bits written as 0 keep their value, and no other access changes the enables.
- R7: A write to 0x14 clears the sticky bits written as 1. When a new detection of a source falls in the same cycle as its acknowledge, the detection wins and the bit stays set.
- R8: `pend_o` equals sticky status AND enable, and `irq_o` is 1 exactly when `pend_o` is nonzero. Disabled sources still set their sticky bits.
- R9: After reset, mode, polarity, enable, sticky, routing and urgency are all zero, and `irq_o` is 0.
- R10: Writes to 0x10, 0x18 and 0x19 are ignored.
- R11: The routing register keeps only bits 1:0 and the urgency register keeps only bit 0. Their upper bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Page (upper byte) and register offset (lower byte) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| src_in | input | NUM_SRC | Asynchronous interrupt inputs |
| pend_o | output | NUM_SRC | Enabled sticky status |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can act on the same sticky bit in the same cycle: a new detection, and a software acknowledge of that bit. The bench raises an input in edge mode and counts two clocks of synchronizer delay. It then places the acknowledge write so that it lands on the very edge at which the detection is captured. The acknowledged bit must read back as set. A second acknowledge, with the input held steady, must then clear it. The per-cycle reference model applies the set after the clear, so the pending and request outputs are compared against that ordering in every cycle around the collision.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [BYTE_W-1:0] {
      OFS_RAW   = 8'h10,
      OFS_MODE  = 8'h11,
      OFS_POLH  = 8'h12,
      OFS_POLL  = 8'h13,
      OFS_ACK   = 8'h14,
      OFS_ENSET = 8'h15,
      OFS_ENCLR = 8'h16,
      OFS_STICK = 8'h18,
      OFS_PEND  = 8'h19,
      OFS_ROUTE = 8'h1A,
      OFS_URG   = 8'h1B
   } reg_ofs_e;

   typedef struct packed {
      logic [BYTE_W-1:0] mode;
      logic [BYTE_W-1:0] polh;
      logic [BYTE_W-1:0] poll;
   } src_cfg_t;
endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 0) begin : g_bad
      $error("pirq_sync: STAGES must be non-negative");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] stg_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
         end else begin
            stg_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
         end
      end
      assign q = stg_q[STAGES-1];
   end
endmodule

// File: rtl/pirq_detect.sv
module pirq_detect
   import pirq_pkg::*;
#(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] level,
   input  src_cfg_t     cfg,
   output logic [N-1:0] hit
);
   logic [N-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level;
   end

   for (genvar i = 0; i < N; i++) begin : g_src
      logic rise, fall, lvl_hit, edg_hit;
      assign rise    = level[i] & ~prev_q[i];
      assign fall    = ~level[i] & prev_q[i];
      assign edg_hit = (cfg.polh[i] & rise) | (cfg.poll[i] & fall);
      assign lvl_hit = (cfg.polh[i] & level[i]) | (cfg.poll[i] & ~level[i]);
      assign hit[i]  = cfg.mode[i] ? edg_hit : lvl_hit;
   end

   // R5: a level-mode source at its active level reports every cycle
   assert_level_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((~cfg.mode[N-1:0] & cfg.polh[N-1:0] & level & ~hit) == '0));
endmodule

// File: rtl/pirq_stat.sv
module pirq_stat #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] hit,
   input  logic [N-1:0] ack_mask,
   input  logic [N-1:0] en_set,
   input  logic [N-1:0] en_clr,
   output logic [N-1:0] stick_o,
   output logic [N-1:0] en_o,
   output logic [N-1:0] pend_o
);
   logic [N-1:0] stick_q, en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stick_q <= '0;
         en_q    <= '0;
      end else begin
         stick_q <= (stick_q & ~ack_mask) | hit;
         en_q    <= (en_q | en_set) & ~en_clr;
      end
   end

   assign stick_o = stick_q;
   assign en_o    = en_q;
   assign pend_o  = stick_q & en_q;

   assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |=> ((stick_q & $past(hit)) == $past(hit)));

   assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|ack_mask) |=> ((stick_q & $past(ack_mask) & ~$past(hit)) == '0));

   assert_enset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|en_set) |=> ((en_q & $past(en_set)) == $past(en_set)));

   assert_enclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|en_clr) |=> ((en_q & $past(en_clr)) == '0));

   assert_enhold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_set == '0 && en_clr == '0) |=> $stable(en_q));
endmodule

// File: rtl/pirq_regblk.sv
module pirq_regblk
   import pirq_pkg::*;
#(
   parameter int          NUM_SRC     = 8,
   parameter int          ADDR_W      = 16,
   parameter int          SYNC_STAGES = 2,
   parameter int unsigned PAGE_ID     = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [7:0]         bus_wdata,
   output logic [7:0]         bus_rdata,
   input  logic [NUM_SRC-1:0] src_in,
   output logic [NUM_SRC-1:0] pend_o,
   output logic               irq_o
);
   localparam int PAGE_W  = ADDR_W - BYTE_W;
   localparam int ROUTE_W = 2;

   if (NUM_SRC < 1 || NUM_SRC > BYTE_W) begin : g_bad_n
      $error("pirq_regblk: NUM_SRC must lie in 1..8");
   end
   if (ADDR_W <= BYTE_W) begin : g_bad_a
      $error("pirq_regblk: ADDR_W must exceed one byte");
   end

   logic                   page_ok, wr_hit;
   logic [BYTE_W-1:0]      ofs;
   logic [NUM_SRC-1:0]     raw, hit, stick, en, wmask;
   logic [NUM_SRC-1:0]     ack_mask, en_set, en_clr;
   logic [NUM_SRC-1:0]     mode_q, polh_q, poll_q;
   logic [ROUTE_W-1:0]     route_q;
   logic                   urg_q;
   src_cfg_t               cfg;

   assign page_ok = (bus_addr[ADDR_W-1:BYTE_W] == PAGE_W'(PAGE_ID));
   assign ofs     = bus_addr[BYTE_W-1:0];
   assign wr_hit  = bus_sel & bus_we & page_ok;
   assign wmask   = bus_wdata[NUM_SRC-1:0];

   assign ack_mask = (wr_hit && ofs == OFS_ACK)   ? wmask : '0;
   assign en_set   = (wr_hit && ofs == OFS_ENSET) ? wmask : '0;
   assign en_clr   = (wr_hit && ofs == OFS_ENCLR) ? wmask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         polh_q  <= '0;
         poll_q  <= '0;
         route_q <= '0;
         urg_q   <= 1'b0;
      end else if (wr_hit) begin
         case (ofs)
            OFS_MODE:  mode_q  <= wmask;
            OFS_POLH:  polh_q  <= wmask;
            OFS_POLL:  poll_q  <= wmask;
            OFS_ROUTE: route_q <= bus_wdata[ROUTE_W-1:0];
            OFS_URG:   urg_q   <= bus_wdata[0];
            default: ;
         endcase
      end
   end

   assign cfg.mode = BYTE_W'(mode_q);
   assign cfg.polh = BYTE_W'(polh_q);
   assign cfg.poll = BYTE_W'(poll_q);

   pirq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(src_in), .q(raw));

   pirq_detect #(.N(NUM_SRC)) u_detect (
      .clk(clk), .rst_n(rst_n), .level(raw), .cfg(cfg), .hit(hit));

   pirq_stat #(.N(NUM_SRC)) u_stat (
      .clk(clk), .rst_n(rst_n), .hit(hit), .ack_mask(ack_mask),
      .en_set(en_set), .en_clr(en_clr),
      .stick_o(stick), .en_o(en), .pend_o(pend_o));

   assign irq_o = |pend_o;

   always_comb begin
      bus_rdata = '0;
      if (page_ok) begin
         case (ofs)
            OFS_RAW:   bus_rdata = BYTE_W'(raw);
            OFS_MODE:  bus_rdata = BYTE_W'(mode_q);
            OFS_POLH:  bus_rdata = BYTE_W'(polh_q);
            OFS_POLL:  bus_rdata = BYTE_W'(poll_q);
            OFS_ENSET: bus_rdata = BYTE_W'(en);
            OFS_STICK: bus_rdata = BYTE_W'(stick);
            OFS_PEND:  bus_rdata = BYTE_W'(pend_o);
            OFS_ROUTE: bus_rdata = BYTE_W'(route_q);
            OFS_URG:   bus_rdata = BYTE_W'(urg_q);
            default:   bus_rdata = '0;
         endcase
      end
   end

   assert_foreign_page_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && !page_ok) |=>
         ($stable(mode_q) && $stable(polh_q) && $stable(poll_q) &&
          $stable(route_q) && $stable(urg_q)));
endmodule

// File: tb/pirq_regblk_test.sv
module pirq_regblk_test;
   localparam int PERIOD = 10;
   localparam logic [7:0] PG = 8'h05;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [7:0]  src_in = '0;
   logic [7:0]  pend_o;
   logic        irq_o;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   pirq_regblk #(.NUM_SRC(8), .ADDR_W(16), .SYNC_STAGES(2), .PAGE_ID(5)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .src_in(src_in), .pend_o(pend_o), .irq_o(irq_o));

   always #(PERIOD/2) clk = ~clk;

   // behavioural reference model
   logic [7:0] m_s1, m_s2, m_prev, m_stick, m_en, m_mode, m_ph, m_pl;
   logic [1:0] m_route;
   logic       m_urg;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_prev = 0; m_stick = 0; m_en = 0;
         m_mode = 0; m_ph = 0; m_pl = 0; m_route = 0; m_urg = 0;
      end else begin
         logic [7:0] ev;
         logic       w;
         for (int b = 0; b < 8; b++) begin
            if (m_mode[b])
               ev[b] = (m_ph[b] && m_s2[b] && !m_prev[b]) || (m_pl[b] && !m_s2[b] && m_prev[b]);
            else
               ev[b] = (m_ph[b] && m_s2[b]) || (m_pl[b] && !m_s2[b]);
         end
         w = bus_sel && bus_we && bus_addr[15:8] == PG;
         if (w && bus_addr[7:0] == 8'h14) m_stick = m_stick & ~bus_wdata;
         m_stick = m_stick | ev;
         if (w) begin
            case (bus_addr[7:0])
               8'h11: m_mode = bus_wdata;
               8'h12: m_ph = bus_wdata;
               8'h13: m_pl = bus_wdata;
               8'h15: m_en = m_en | bus_wdata;
               8'h16: m_en = m_en & ~bus_wdata;
               8'h1A: m_route = bus_wdata[1:0];
               8'h1B: m_urg = bus_wdata[0];
               default: ;
            endcase
         end
         m_prev = m_s2; m_s2 = m_s1; m_s1 = src_in;
      end
   end

   function automatic logic [7:0] exp_rd(input logic [15:0] a);
      if (a[15:8] != PG) return 8'h00;
      case (a[7:0])
         8'h10: return m_s2;
         8'h11: return m_mode;
         8'h12: return m_ph;
         8'h13: return m_pl;
         8'h15: return m_en;
         8'h18: return m_stick;
         8'h19: return m_stick & m_en;
         8'h1A: return {6'b0, m_route};
         8'h1B: return {7'b0, m_urg};
         default: return 8'h00;
      endcase
   endfunction

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // per-cycle comparison of outputs (R8)
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         chk(pend_o, m_stick & m_en, "R8 pend");
         chk({7'b0, irq_o}, {7'b0, |(m_stick & m_en)}, "R8 irq");
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] pg, input logic [7:0] ofs, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1; bus_we = 1; bus_addr = {pg, ofs}; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_we = 0;
   endtask

   task automatic rd(input logic [7:0] pg, input logic [7:0] ofs, input string req,
                     output logic [7:0] got);
      @(negedge clk);
      bus_sel = 1; bus_we = 0; bus_addr = {pg, ofs};
      #1;
      got = bus_rdata;
      chk(got, exp_rd({pg, ofs}), req);
      bus_sel = 0;
   endtask

   initial begin
      #(PERIOD * 100000);
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] v;
      tick(3);
      rst_n = 1;
      // R9 reset state
      foreach (v[i]) ;
      for (int o = 8'h10; o <= 8'h1B; o++) rd(PG, 8'(o), "R9", v);
      chk({7'b0, irq_o}, 8'h00, "R9 irq");
      // R2 unmapped and write-only offsets
      rd(PG, 8'h00, "R2", v); chk(v, 8'h00, "R2");
      rd(PG, 8'h17, "R2", v); chk(v, 8'h00, "R2");
      rd(PG, 8'h1C, "R2", v); chk(v, 8'h00, "R2");
      // R11 routing / urgency width
      wr(PG, 8'h1A, 8'hFF); rd(PG, 8'h1A, "R11", v); chk(v, 8'h03, "R11");
      wr(PG, 8'h1B, 8'hFF); rd(PG, 8'h1B, "R11", v); chk(v, 8'h01, "R11");
      // configuration: bit0 level-high, bit1 rise, bit2 fall, bit3 both, bit4 rise
      wr(PG, 8'h11, 8'h1E); wr(PG, 8'h12, 8'h1B); wr(PG, 8'h13, 8'h0C);
      rd(PG, 8'h11, "R2", v); chk(v, 8'h1E, "R2");
      rd(PG, 8'h12, "R2", v); chk(v, 8'h1B, "R2");
      rd(PG, 8'h13, "R2", v); chk(v, 8'h0C, "R2");
      rd(PG, 8'h14, "R2", v); chk(v, 8'h00, "R2");
      // R3 synchronizer latency
      @(negedge clk); src_in = 8'h80;
      rd(PG, 8'h10, "R3", v); chk(v, 8'h00, "R3 after one edge");
      rd(PG, 8'h10, "R3", v); chk(v, 8'h80, "R3 after two edges");
      @(negedge clk); src_in = 8'h00; tick(3);
      // R4 edges
      @(negedge clk); src_in = 8'h0E; tick(4);
      rd(PG, 8'h18, "R4", v); chk(v, 8'h0A, "R4 rising");
      @(negedge clk); src_in = 8'h00; tick(4);
      rd(PG, 8'h18, "R4", v); chk(v, 8'h0E, "R4 falling and both");
      wr(PG, 8'h14, 8'hFF);
      rd(PG, 8'h18, "R7", v); chk(v, 8'h00, "R7 ack");
      // R5 level persistence
      @(negedge clk); src_in = 8'h01; tick(4);
      rd(PG, 8'h18, "R5", v); chk(v, 8'h01, "R5");
      wr(PG, 8'h14, 8'h01);
      rd(PG, 8'h18, "R5", v); chk(v, 8'h01, "R5 re-set after ack");
      @(negedge clk); src_in = 8'h00; tick(4);
      wr(PG, 8'h14, 8'h01);
      rd(PG, 8'h18, "R5", v); chk(v, 8'h00, "R5 released");
      // R6 enables
      wr(PG, 8'h15, 8'h0F); wr(PG, 8'h16, 8'h05);
      rd(PG, 8'h15, "R6", v); chk(v, 8'h0A, "R6");
      rd(PG, 8'h16, "R2", v); chk(v, 8'h00, "R2 enclr reads zero");
      // R8 pending gated by enable
      @(negedge clk); src_in = 8'h06; tick(4);
      rd(PG, 8'h19, "R8", v); chk(v, 8'h02, "R8 pending");
      chk({7'b0, irq_o}, 8'h01, "R8 irq high");
      wr(PG, 8'h16, 8'hFF);
      chk({7'b0, irq_o}, 8'h00, "R8 irq low");
      rd(PG, 8'h18, "R8", v); chk(v, 8'h02, "R8 latched while disabled");
      @(negedge clk); src_in = 8'h00; tick(4);
      wr(PG, 8'h14, 8'hFF);
      // R7 acknowledge collides with detection
      @(negedge clk); src_in = 8'h10;
      @(negedge clk);
      @(negedge clk);
      bus_sel = 1; bus_we = 1; bus_addr = {PG, 8'h14}; bus_wdata = 8'h10;
      @(negedge clk);
      bus_sel = 0; bus_we = 0;
      rd(PG, 8'h18, "R7", v); chk(v, 8'h10, "R7 detection wins");
      wr(PG, 8'h14, 8'h10);
      rd(PG, 8'h18, "R7", v); chk(v, 8'h00, "R7 later ack");
      // R10 read-only registers
      wr(PG, 8'h18, 8'hFF); wr(PG, 8'h19, 8'hFF); wr(PG, 8'h10, 8'hFF);
      rd(PG, 8'h18, "R10", v); chk(v, 8'h00, "R10");
      rd(PG, 8'h10, "R10", v); chk(v, 8'h10, "R10");
      // R1 foreign page
      wr(8'h06, 8'h11, 8'h00); wr(8'h06, 8'h15, 8'hFF);
      rd(PG, 8'h11, "R1", v); chk(v, 8'h1E, "R1 config kept");
      rd(PG, 8'h15, "R1", v); chk(v, 8'h00, "R1 enable kept");
      rd(8'h06, 8'h11, "R1", v); chk(v, 8'h00, "R1 foreign read");
      tick(2);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule